// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a two-wire bus target that sits in front of a small byte-wide storage array. It oversamples the clock and data lines with the system clock. It recognises start, repeated start and stop conditions. It compares the first byte of each transfer against a fixed 7-bit device address and pulls the data line low through an open-drain output enable.

A single location pointer is kept across transfers. A write transfer loads the pointer from its second byte, and any further bytes are stored at successive locations. A read transfer always begins at the pointer. A read can start at a chosen location by first sending a write that carries only the location byte, then a repeated start and a read header. A read can also resume wherever the previous access stopped. A read keeps going for as long as the controller acknowledges each byte.

Top module: `i2c_serial_mem`

## Requirements
- R1: During and after reset, `sda_oe` is low, the pointer is 0 and every array byte is 0x00, so a read issued right after reset returns 0x00.
- R2: When the header byte (7 address bits, most significant first, then the direction bit where 1 means read) matches `DEV_ADDR`, the target holds `sda_oe` high through the 9th clock, whatever the direction.
- R3: When the header does not match, the target never acknowledges and never drives the line, and ignores every following byte until the next start. Bytes sent in that window leave the array unchanged.
- R4: In a write transfer, the first byte after the header loads the pointer. Each later byte is stored at the pointer, which then advances by one. Every one of these bytes is acknowledged.
- R5: A write that carries only the location byte, followed by a repeated start and a read header, returns the byte at that location first.
- R6: A read issued without a location returns the byte that follows the last byte accessed, whether that access was a read or a write.
- R7: Each byte the controller acknowledges in a read is followed by the next location. The pointer wraps from the last location to location 0, for reads and for writes.
- R8: After the controller does not acknowledge a read byte, the target keeps `sda_oe` low until the next start. Clocks in that window read as all ones.
- R9: A stop or a start seen in the middle of a byte abandons it. A partly received data byte is not stored. A pointer already loaded by a location byte keeps that value.
- R10: The target changes `sda_oe` only while the sampled clock line is low. The only exception is releasing the line on a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with `ADDR_W` = 8, `DEV_ADDR` = 7'h3A and two synchroniser stages. The full 8-bit location byte therefore reaches the pointer, and the last location 0xFF can be reached with a single location write, which makes both wrap directions cheap to exercise. The chosen address has neighbours that differ only in the lowest address bit, so a header that is wrong by one bit tests the comparator at its edge. With two synchroniser stages, the target reacts about four system clocks after a bus edge. A bus quarter-period of six system clocks leaves a margin for acknowledge timing and for the check that the data line stays steady while the clock is high.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADR,
        ST_WDAT,
        ST_ACK,
        ST_RD,
        ST_RACK
    } st_e;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr_q, sda_sr_q;
    logic              scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sr_q[0] <= scl_i;
            sda_sr_q[0] <= sda_i;
            for (int i = 1; i < STAGES; i++) begin
                scl_sr_q[i] <= scl_sr_q[i-1];
                sda_sr_q[i] <= sda_sr_q[i-1];
            end
            scl_p_q <= scl_sr_q[STAGES-1];
            sda_p_q <= sda_sr_q[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sr_q[STAGES-1];
    assign sda_lvl   = sda_sr_q[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_p_q;
    assign scl_fall  = ~scl_lvl & scl_p_q;
    assign start_det = scl_lvl & scl_p_q & sda_p_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_p_q & ~sda_p_q & sda_lvl;
endmodule

// File: rtl/i2cm_mem_array.sv
module i2cm_mem_array
    import i2cm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);
    localparam int DEPTH = 1 << AW;

    byte_t mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    AST_WR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown({waddr, wdata})); // R4
endmodule

// File: rtl/i2c_serial_mem.sv
module i2c_serial_mem
    import i2cm_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int            AW  = ADDR_W;
    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        st_e           st;
        st_e           ret;
        logic [3:0]    cnt;
        byte_t         shr;
        byte_t         tx;
        logic [AW-1:0] ptr;
        logic          oe;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    logic  scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic  we_d;
    byte_t rdata;

    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cm_mem_array #(.AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_d),
        .waddr (ctl_q.ptr),
        .wdata (ctl_q.shr),
        .raddr (ctl_q.ptr),
        .rdata (rdata)
    );

    always_comb begin
        ctl_d = ctl_q;
        we_d  = 1'b0;
        if (stop_det) begin
            ctl_d.st = ST_IDLE;
        end else if (start_det) begin
            ctl_d.st  = ST_DEV;
            ctl_d.cnt = '0;
        end else begin
            case (ctl_q.st)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        ctl_d.shr = {ctl_q.shr[6:0], sda_lvl};
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'd8) begin
                        ctl_d.st  = ST_ACK;
                        ctl_d.cnt = '0;
                        if (ctl_q.st == ST_DEV) begin
                            if (ctl_q.shr[7:1] == DEV_ADDR)
                                ctl_d.ret = ctl_q.shr[0] ? ST_RD : ST_WADR;
                            else
                                ctl_d.st = ST_IDLE;
                        end else if (ctl_q.st == ST_WADR) begin
                            ctl_d.ptr = ctl_q.shr[AW-1:0];
                            ctl_d.ret = ST_WDAT;
                        end else begin
                            we_d      = 1'b1;
                            ctl_d.ptr = ctl_q.ptr + ONE;
                            ctl_d.ret = ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ctl_d.st  = ctl_q.ret;
                        ctl_d.cnt = '0;
                        if (ctl_q.ret == ST_RD) ctl_d.tx = rdata;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (ctl_q.cnt == 4'd8) begin
                            ctl_d.st  = ST_RACK;
                            ctl_d.ptr = ctl_q.ptr + ONE;
                        end else begin
                            ctl_d.tx = {ctl_q.tx[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ctl_d.shr[0] = sda_lvl;
                    end else if (scl_fall) begin
                        if (!ctl_q.shr[0]) begin
                            ctl_d.st  = ST_RD;
                            ctl_d.cnt = '0;
                            ctl_d.tx  = rdata;
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
        ctl_d.oe = (ctl_d.st == ST_ACK) || (ctl_d.st == ST_RD && !ctl_d.tx[7]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= ST_IDLE;
            ctl_q.ret <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe = ctl_q.oe;

    AST_DEV_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_DEV && scl_fall && ctl_q.cnt == 4'd8 && !start_det && !stop_det
         && ctl_q.shr[7:1] == DEV_ADDR) |=> sda_oe); // R2
    AST_DEV_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_DEV && scl_fall && ctl_q.cnt == 4'd8 && !start_det && !stop_det
         && ctl_q.shr[7:1] != DEV_ADDR) |=> !sda_oe); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && !start_det) |=> !sda_oe); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.ptr) |-> (ctl_q.ptr == $past(ctl_q.ptr) + ONE) || $past(ctl_q.st == ST_WADR)); // R7
    AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> ctl_q.st == ST_DEV); // R9
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_lvl || $past(start_det || stop_det))); // R10
endmodule

// File: tb/i2c_serial_mem_test.sv
module i2c_serial_mem_test;
    localparam logic [6:0] DEV = 7'h3A;
    localparam int         Q   = 6;
    localparam logic [15:0] VEC [8] = '{
        16'h00A5, 16'h013C, 16'h02F0, 16'h7F11,
        16'h8022, 16'hFEEE, 16'hFF99, 16'h105A
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;
    int   nchk = 0;
    int   nerr = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    i2c_serial_mem #(.DEV_ADDR(DEV), .ADDR_W(8), .SYNC_STAGES(2)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b, output logic stab);
        logic o1;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        b = sda_bus; o1 = sda_oe; tick(Q);
        stab = (o1 == sda_oe); scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic a, s;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a, s);
        ack = !a;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] v);
        logic b, s;
        logic all_s = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, s);
            v[i] = b;
            all_s &= s;
        end
        check("R10 line steady while clock high", int'(all_s), 1);
        put_bit(!mack);
    endtask

    task automatic rd_body(input int n, input logic [7:0] e0, e1, e2, input string req);
        logic [7:0] e [3];
        logic [7:0] v;
        e = '{e0, e1, e2};
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, v);
            check(req, int'(v), int'(e[k]));
        end
        bus_stop();
    endtask

    task automatic wr_seq(input logic [7:0] a, input int n, input logic [7:0] d0, d1, d2,
                          input string req);
        logic ack;
        logic [7:0] d [3];
        d = '{d0, d1, d2};
        bus_start();
        wr_byte({DEV, 1'b0}, ack); check("R2 write header ack", int'(ack), 1);
        wr_byte(a, ack); check(req, int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            wr_byte(d[k], ack); check(req, int'(ack), 1);
        end
        bus_stop();
    endtask

    task automatic sel_read(input logic [7:0] a, input int n, input logic [7:0] e0, e1, e2,
                            input string req);
        logic ack;
        bus_start();
        wr_byte({DEV, 1'b0}, ack); check("R2 write header ack", int'(ack), 1);
        wr_byte(a, ack); check("R5 location ack", int'(ack), 1);
        bus_start();
        wr_byte({DEV, 1'b1}, ack); check("R2 read header ack", int'(ack), 1);
        rd_body(n, e0, e1, e2, req);
    endtask

    task automatic imm_read(input int n, input logic [7:0] e0, e1, e2, input string req);
        logic ack;
        bus_start();
        wr_byte({DEV, 1'b1}, ack); check("R2 read header ack", int'(ack), 1);
        rd_body(n, e0, e1, e2, req);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        tick(5);
        check("R1 oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(5);
        check("R1 oe after reset", int'(sda_oe), 0);
        imm_read(1, 8'h00, 8'h00, 8'h00, "R1 first read after reset");

        for (int i = 0; i < 8; i++) begin
            wr_seq(VEC[i][15:8], 1, VEC[i][7:0], 8'h00, 8'h00, "R4 single write");
            sel_read(VEC[i][15:8], 1, VEC[i][7:0], 8'h00, 8'h00, "R5 selective read");
        end

        wr_seq(8'h40, 3, 8'h61, 8'h62, 8'h63, "R4 multi-byte write");
        sel_read(8'h40, 3, 8'h61, 8'h62, 8'h63, "R7 sequential read");
        sel_read(8'h40, 1, 8'h61, 8'h00, 8'h00, "R5 selective read");
        imm_read(1, 8'h62, 8'h00, 8'h00, "R6 resume after read");
        imm_read(1, 8'h63, 8'h00, 8'h00, "R6 resume again");
        wr_seq(8'h44, 1, 8'h7E, 8'h00, 8'h00, "R4 single write");
        imm_read(1, 8'h00, 8'h00, 8'h00, "R6 resume after write");

        sel_read(8'hFE, 3, 8'hEE, 8'h99, 8'hA5, "R7 read wrap");
        wr_seq(8'hFF, 2, 8'h77, 8'h88, 8'h00, "R7 write wrap");
        sel_read(8'hFF, 2, 8'h77, 8'h88, 8'h00, "R7 write wrap readback");

        bus_start();
        wr_byte({DEV ^ 7'h01, 1'b0}, ack); check("R3 no ack on mismatch", int'(ack), 0);
        wr_byte(8'h02, ack); check("R3 ignored byte", int'(ack), 0);
        wr_byte(8'h55, ack); check("R3 ignored byte", int'(ack), 0);
        bus_stop();
        sel_read(8'h02, 1, 8'hF0, 8'h00, 8'h00, "R3 array untouched");
        bus_start();
        wr_byte({DEV ^ 7'h01, 1'b1}, ack); check("R3 no ack on mismatched read", int'(ack), 0);
        rd_byte(1'b0, v); check("R3 line left released", int'(v), 8'hFF);
        bus_stop();

        bus_start();
        wr_byte({DEV, 1'b0}, ack); check("R2 write header ack", int'(ack), 1);
        wr_byte(8'h01, ack); check("R5 location ack", int'(ack), 1);
        bus_start();
        wr_byte({DEV, 1'b1}, ack); check("R2 read header ack", int'(ack), 1);
        rd_byte(1'b0, v); check("R8 last byte", int'(v), 8'h3C);
        rd_byte(1'b0, v); check("R8 released after nack", int'(v), 8'hFF);
        bus_stop();
        imm_read(1, 8'hF0, 8'h00, 8'h00, "R6 resume after nack");

        bus_start();
        wr_byte({DEV, 1'b0}, ack); check("R2 write header ack", int'(ack), 1);
        wr_byte(8'h80, ack); check("R4 location ack", int'(ack), 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        imm_read(1, 8'h22, 8'h00, 8'h00, "R9 stop abandons partial byte");

        bus_start();
        wr_byte({DEV, 1'b0}, ack); check("R2 write header ack", int'(ack), 1);
        wr_byte(8'h7F, ack); check("R4 location ack", int'(ack), 1);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        wr_byte({DEV, 1'b1}, ack); check("R9 header after abort", int'(ack), 1);
        rd_byte(1'b0, v); check("R9 start abandons partial byte", int'(v), 8'h11);
        bus_stop();

        rst_n = 1'b0;
        tick(3);
        check("R1 oe in second reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(3);
        imm_read(2, 8'h00, 8'h00, 8'h00, "R1 array and pointer cleared");

        done = 1'b1;
        finish_run();
    end
endmodule